// File: doc/BRIEF.md
# Two-Channel Disk Controller Interrupt Status Mirror

This block is a small byte-wide configuration register bank for a two-channel disk controller. Each channel owns one interrupt flag. The flag is visible in two places: in a shared mode register and in a per-channel status register. A write-one-to-clear through either place clears the flag in both. The drive-side logic sends one request level per channel. A rising level sets that channel's flag and a falling level clears it.

The mode register also holds one block bit per channel. The single level-sensitive interrupt pin is the OR, over the two channels, of each flag gated by its own block bit. A control register holds one enable bit per channel. The channel 1 enable comes out of reset from a strap input. Reads are registered and return data one cycle after the read strobe. Offsets outside the four handled registers read as zero and ignore writes.

Top module: `ide_irq_mirror`

## Requirements
- R1: A synchronous active-high reset clears both flags and both block bits and drives `irq_out` low. After reset, control offset 0x51 reads 0x04 with bit 3 equal to `sec_enable_strap`.
- R2: Mode offset 0x71 reads the channel 0 flag at bit 2, the channel 1 flag at bit 3, the channel 0 block bit at bit 4 and the channel 1 block bit at bit 5. Bits 4 and 5 are plain read/write bits. All other bits read 0.
- R3: Status offset 0x50 shows the channel 0 flag at bit 2. Status offset 0x57 shows the channel 1 flag at bit 4. All other bits of both read 0.
- R4: A write of 1 to a flag position (0x71 bit 2 or 3, 0x50 bit 2, 0x57 bit 4) clears that flag in every register that shows it. A write of 0 leaves the flag unchanged. No write can set a flag.
- R5: A 0-to-1 change on `chan_req[c]` sets flag c. A 1-to-0 change clears it. A steady level leaves the flag alone.
- R6: `irq_out` equals (flag0 AND NOT block0) OR (flag1 AND NOT block1). It changes on the same clock edge that updates a flag or a block bit.
- R7: When a rising request and a write-one-to-clear of the same flag fall in the same cycle, the flag ends set.
- R8: Control offset 0x51 bits 2 (channel 0 enable) and 3 (channel 1 enable) are read/write. Its other bits read 0.
- R9: Any other offset reads 0, and writes to it change no state.
- R10: `cfg_rdata` takes the addressed value one cycle after `cfg_rd_en`. That value is the state before any write made in the same cycle, and `cfg_rdata` holds when no read is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_rd_en | input | 1 | Configuration read strobe |
| cfg_addr | input | 8 | Byte offset |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Registered read data |
| chan_req | input | 2 | Per-channel interrupt request levels |
| sec_enable_strap | input | 1 | Reset value of the channel 1 enable |
| irq_out | output | 1 | Combined level interrupt |

## Verification
The hardest case to reach is a rising request edge that lands in the same cycle as a clearing write to the same flag (R7). Reaching it needs the request first driven low for a cycle, then raised on exactly the write cycle. The bench sweeps every pairing of initial flag and block states against every write pattern on each handled offset and on an unmapped one. Each write is paired with a read in the same cycle. All three views are then read back and compared with an arithmetic model. Dedicated steps create the edge-and-clear collision for each channel.

// File: rtl/ide_irq_pkg.sv
package ide_irq_pkg;
  localparam int NUM_CH = 2;
  localparam logic [7:0] OFS_STAT0 = 8'h50;
  localparam logic [7:0] OFS_CTRL  = 8'h51;
  localparam logic [7:0] OFS_STAT1 = 8'h57;
  localparam logic [7:0] OFS_MODE  = 8'h71;
  localparam int MODE_FLAG_LSB  = 2;
  localparam int MODE_BLOCK_LSB = 4;
  localparam int CTRL_EN_LSB    = 2;

  function automatic logic [7:0] mirror_ofs(input int ch);
    return (ch == 0) ? OFS_STAT0 : OFS_STAT1;
  endfunction

  function automatic int mirror_bit(input int ch);
    return (ch == 0) ? 2 : 4;
  endfunction
endpackage

// File: rtl/irq_cfg_decode.sv
module irq_cfg_decode
  import ide_irq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  output logic              wr_mode,
  output logic              wr_ctrl,
  output logic [NUM_CH-1:0] wr_stat
);
  always_comb begin
    wr_mode = wr_en && (addr == ADDR_W'(OFS_MODE));
    wr_ctrl = wr_en && (addr == ADDR_W'(OFS_CTRL));
    for (int c = 0; c < NUM_CH; c++) begin
      wr_stat[c] = wr_en && (addr == ADDR_W'(mirror_ofs(c)));
    end
  end
endmodule

// File: rtl/irq_chan_flag.sv
module irq_chan_flag (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic wr_mode,
  input  logic mode_bit,
  input  logic wr_stat,
  input  logic stat_bit,
  output logic req_q,
  output logic flag_d,
  output logic flag_q
);
  logic rise, fall, clr;

  always_comb begin
    rise = req && !req_q;
    fall = !req && req_q;
    clr  = (wr_mode && mode_bit) || (wr_stat && stat_bit);
    if (rise)           flag_d = 1'b1;
    else if (fall)      flag_d = 1'b0;
    else if (clr)       flag_d = 1'b0;
    else                flag_d = flag_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      req_q  <= req;
    end
  end
endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
  import ide_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              strap,
  input  logic              wr_mode,
  input  logic              wr_ctrl,
  input  logic [NUM_CH-1:0] block_wdata,
  input  logic [NUM_CH-1:0] en_wdata,
  output logic [NUM_CH-1:0] block_d,
  output logic [NUM_CH-1:0] block_q,
  output logic [NUM_CH-1:0] en_q
);
  always_comb begin
    block_d = wr_mode ? block_wdata : block_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      block_q <= '0;
      en_q    <= '0;
      en_q[0] <= 1'b1;
      en_q[1] <= strap;
    end else begin
      block_q <= block_d;
      if (wr_ctrl) en_q <= en_wdata;
    end
  end
endmodule

// File: rtl/irq_combine.sv
module irq_combine
  import ide_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] flag_d,
  input  logic [NUM_CH-1:0] block_d,
  output logic              irq_out
);
  always_ff @(posedge clk) begin
    if (rst) irq_out <= 1'b0;
    else     irq_out <= |(flag_d & ~block_d);
  end
endmodule

// File: rtl/irq_readback.sv
module irq_readback
  import ide_irq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NUM_CH-1:0] flag_q,
  input  logic [NUM_CH-1:0] block_q,
  input  logic [NUM_CH-1:0] en_q,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] view;

  always_comb begin
    view = '0;
    if (addr == ADDR_W'(OFS_MODE)) begin
      view[MODE_FLAG_LSB  +: NUM_CH] = flag_q;
      view[MODE_BLOCK_LSB +: NUM_CH] = block_q;
    end
    if (addr == ADDR_W'(OFS_CTRL)) begin
      view[CTRL_EN_LSB +: NUM_CH] = en_q;
    end
    for (int c = 0; c < NUM_CH; c++) begin
      if (addr == ADDR_W'(mirror_ofs(c))) view[mirror_bit(c)] = flag_q[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= view;
  end
endmodule

// File: rtl/ide_irq_mirror.sv
module ide_irq_mirror
  import ide_irq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr_en,
  input  logic              cfg_rd_en,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic [NUM_CH-1:0] chan_req,
  input  logic              sec_enable_strap,
  output logic              irq_out
);
  logic              wr_mode, wr_ctrl;
  logic [NUM_CH-1:0] wr_stat;
  logic [NUM_CH-1:0] req_q, flag_d, flag_q;
  logic [NUM_CH-1:0] block_d, block_q, en_q;

  irq_cfg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wr_en(cfg_wr_en), .addr(cfg_addr),
    .wr_mode(wr_mode), .wr_ctrl(wr_ctrl), .wr_stat(wr_stat)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    irq_chan_flag u_flag (
      .clk(clk), .rst(rst), .req(chan_req[c]),
      .wr_mode(wr_mode), .mode_bit(cfg_wdata[MODE_FLAG_LSB + c]),
      .wr_stat(wr_stat[c]), .stat_bit(cfg_wdata[mirror_bit(c)]),
      .req_q(req_q[c]), .flag_d(flag_d[c]), .flag_q(flag_q[c])
    );
  end

  irq_ctrl_regs u_regs (
    .clk(clk), .rst(rst), .strap(sec_enable_strap),
    .wr_mode(wr_mode), .wr_ctrl(wr_ctrl),
    .block_wdata(cfg_wdata[MODE_BLOCK_LSB +: NUM_CH]),
    .en_wdata(cfg_wdata[CTRL_EN_LSB +: NUM_CH]),
    .block_d(block_d), .block_q(block_q), .en_q(en_q)
  );

  irq_combine u_irq (
    .clk(clk), .rst(rst), .flag_d(flag_d), .block_d(block_d), .irq_out(irq_out)
  );

  irq_readback #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst(rst), .rd_en(cfg_rd_en), .addr(cfg_addr),
    .flag_q(flag_q), .block_q(block_q), .en_q(en_q), .rdata(cfg_rdata)
  );
endmodule

// File: rtl/ide_irq_mirror_chk.sv
module ide_irq_mirror_chk
  import ide_irq_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [NUM_CH-1:0] chan_req,
  input logic [NUM_CH-1:0] req_q,
  input logic [NUM_CH-1:0] flag_q,
  input logic [NUM_CH-1:0] block_q,
  input logic              irq_out
);
  a_r1_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> (flag_q == '0 && block_q == '0 && !irq_out));

  a_r6_irq_level: assert property (@(posedge clk) disable iff (rst)
    irq_out == |(flag_q & ~block_q));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // R5 and R7: a rising request always leaves the flag set
    a_r5_rise_sets: assert property (@(posedge clk) disable iff (rst)
      (chan_req[c] && !req_q[c]) |=> flag_q[c]);
    a_r5_fall_clears: assert property (@(posedge clk) disable iff (rst)
      (!chan_req[c] && req_q[c]) |=> !flag_q[c]);
    a_r4_write_never_sets: assert property (@(posedge clk) disable iff (rst)
      (!flag_q[c] && !(chan_req[c] && !req_q[c])) |=> !flag_q[c]);
  end
endmodule

bind ide_irq_mirror ide_irq_mirror_chk u_chk (
  .clk(clk), .rst(rst), .chan_req(chan_req), .req_q(req_q),
  .flag_q(flag_q), .block_q(block_q), .irq_out(irq_out)
);

// File: tb/test_ide_irq_mirror.sv
module test_ide_irq_mirror;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst, wr, rd, strap;
  logic [7:0] addr, wdata;
  logic [1:0] req;
  wire  [7:0] rdata;
  wire        irq;

  int n_chk = 0;
  int n_bad = 0;

  logic [1:0] m_flag, m_blk, m_en, m_prev;

  always #(CLK_PERIOD/2) clk = ~clk;

  ide_irq_mirror i_ide_irq_mirror (
    .clk(clk), .rst(rst), .cfg_wr_en(wr), .cfg_rd_en(rd), .cfg_addr(addr),
    .cfg_wdata(wdata), .cfg_rdata(rdata), .chan_req(req),
    .sec_enable_strap(strap), .irq_out(irq)
  );

  function automatic logic [7:0] m_ofs(input int c);
    return (c == 0) ? 8'h50 : 8'h57;
  endfunction
  function automatic int m_bit(input int c);
    return (c == 0) ? 2 : 4;
  endfunction

  function automatic logic [7:0] m_view(input logic [7:0] a);
    logic [7:0] v = 8'h00;
    if (a == 8'h71) v = {2'b00, m_blk, m_flag, 2'b00};
    if (a == 8'h51) v = {4'h0, m_en, 2'b00};
    if (a == 8'h50) v[2] = m_flag[0];
    if (a == 8'h57) v[4] = m_flag[1];
    return v;
  endfunction

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic r, input logic [7:0] a,
                      input logic [7:0] d, input logic [1:0] q, input string tag);
    logic [7:0] exp_rd;
    logic [1:0] rise, fall, clr;
    @(negedge clk);
    wr = w; rd = r; addr = a; wdata = d; req = q;
    exp_rd = m_view(a);
    rise = q & ~m_prev;
    fall = ~q & m_prev;
    for (int c = 0; c < 2; c++) begin
      clr[c] = w && ((a == 8'h71 && d[2+c]) || (a == m_ofs(c) && d[m_bit(c)]));
      if (rise[c])      m_flag[c] = 1'b1;
      else if (fall[c]) m_flag[c] = 1'b0;
      else if (clr[c])  m_flag[c] = 1'b0;
    end
    if (w && a == 8'h71) m_blk = d[5:4];
    if (w && a == 8'h51) m_en  = d[3:2];
    m_prev = q;
    @(posedge clk);
    #1;
    check8({"R6 irq ", tag}, {7'd0, irq}, {7'd0, |(m_flag & ~m_blk)});
    if (r) check8({"R10 read ", tag}, rdata, exp_rd);
  endtask

  task automatic do_reset(input logic s);
    @(negedge clk);
    rst = 1'b1; strap = s; wr = 1'b0; rd = 1'b0; req = 2'b00;
    addr = 8'h00; wdata = 8'h00;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_flag = 2'b00; m_blk = 2'b00; m_en = {s, 1'b1}; m_prev = 2'b00;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] targets [5];
    targets[0] = 8'h50; targets[1] = 8'h51; targets[2] = 8'h57;
    targets[3] = 8'h71; targets[4] = 8'h63;

    // R1 reset with strap high
    do_reset(1'b1);
    check8("R1 irq after reset", {7'd0, irq}, 8'h00);
    step(0, 1, 8'h51, 8'h00, 2'b00, "R1 R8 ctrl reset");
    check8("R1 ctrl strap=1", rdata, 8'h0C);
    step(0, 1, 8'h71, 8'h00, 2'b00, "R1 R2 mode reset");
    check8("R1 mode cleared", rdata, 8'h00);

    // Sweep: flag/block start state x target x write pattern
    for (int st = 0; st < 16; st++) begin
      for (int t = 0; t < 5; t++) begin
        for (int wd = 0; wd < 64; wd++) begin
          step(1, 0, 8'h71, {2'b00, st[3:2], 2'b11, 2'b00}, 2'b00, "setup");
          step(0, 0, 8'h00, 8'h00, st[1:0], "R5 set");
          step(1, 1, targets[t], 8'(wd << 2), st[1:0], "R4 R9 write");
          step(0, 1, 8'h71, 8'h00, st[1:0], "R2 R4 mode");
          step(0, 1, 8'h50, 8'h00, st[1:0], "R3 R4 stat0");
          step(0, 1, 8'h57, 8'h00, st[1:0], "R3 R4 stat1");
          step(0, 1, 8'h51, 8'h00, st[1:0], "R8 R9 ctrl");
        end
      end
    end

    // R5 directed edges
    step(1, 0, 8'h71, 8'h0C, 2'b00, "R5 prep");
    step(0, 0, 8'h00, 8'h00, 2'b10, "R5 rise ch1");
    step(0, 1, 8'h57, 8'h00, 2'b10, "R5 stat1");
    check8("R5 rise sets ch1", rdata, 8'h10);
    step(0, 0, 8'h00, 8'h00, 2'b10, "R5 steady");
    step(0, 1, 8'h71, 8'h00, 2'b00, "R5 fall ch1");
    step(0, 1, 8'h71, 8'h00, 2'b00, "R5 read");
    check8("R5 fall clears ch1", rdata, 8'h00);

    // R7 collision: rising request with same-cycle clear, each channel
    step(1, 0, 8'h50, 8'h04, 2'b01, "R7 ch0");
    step(0, 1, 8'h50, 8'h00, 2'b01, "R7 ch0 read");
    check8("R7 request beats clear ch0", rdata, 8'h04);
    step(1, 0, 8'h71, 8'h08, 2'b11, "R7 ch1");
    step(0, 1, 8'h71, 8'h00, 2'b11, "R7 ch1 read");
    check8("R7 request beats clear ch1", rdata, 8'h0C);
    check8("R7 R6 irq high", {7'd0, irq}, 8'h01);

    // R9 unmapped write changes nothing
    step(1, 0, 8'h60, 8'hFF, 2'b11, "R9 write");
    step(0, 1, 8'h60, 8'h00, 2'b11, "R9 read");
    check8("R9 unmapped reads zero", rdata, 8'h00);
    step(0, 1, 8'h71, 8'h00, 2'b11, "R9 mode");
    check8("R9 state untouched", rdata, 8'h0C);

    // R10 hold when no read
    step(0, 0, 8'h51, 8'h00, 2'b11, "R10 hold");
    check8("R10 rdata holds", rdata, 8'h0C);

    // R1 reset with strap low
    do_reset(1'b0);
    step(0, 1, 8'h51, 8'h00, 2'b00, "R1 ctrl");
    check8("R1 ctrl strap=0", rdata, 8'h04);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule